// File: doc/BRIEF.md
# Data-Space Router with Core-Held Special Registers

This block sits between a small processor core and its byte-wide data space. Every load and store the core issues carries a flat data address, and the router decides where it lands. The lowest addresses select a byte of the general-purpose register file, which lives outside the block and is reached through a narrow read/write port. The following range is the I/O window. Eight ports at its top, 0x38 through 0x3F, are owned by the core and held inside the router. All other addresses, including I/O ports below 0x38, go to an external byte memory port.

The registers held locally are five extended-address page bytes, the two stack-pointer bytes and the status byte. Each page byte is presented to the core already shifted into bits 23:16 of a 24-bit value. Build-time switches remove individual page registers and the high stack-pointer byte. A removed register ignores stores and reads as zero.

The core has one read request channel and one write request channel, and each can present a request every cycle. Register-file and local accesses are accepted at once. Memory accesses wait for the memory's ready signal. Read data always returns on a separate valid strobe one cycle after the read is accepted.

Top module: `dspace_router`

## Requirements
- R1: Data addresses 0x00–0x1F go only to the register file. A store raises `rf_wr_en` with index equal to the address, and a load returns `rf_rd_data` for index equal to the address. Neither touches the memory port.
- R2: Data addresses 0x58–0x5F (I/O ports 0x38–0x3F) are served locally and never appear on the memory port. Addresses 0x20–0x57 (I/O ports below 0x38) and 0x60 and above are forwarded to memory with `mem_addr` equal to the data address and `mem_wdata` equal to the store byte.
- R3: Data addresses 0x58, 0x59, 0x5A, 0x5B and 0x5C are the D, X, Y and Z page registers and the indirect-jump page register, in that order. A store places the byte in bits 23:16 of the matching 24-bit output, and bits 15:0 stay zero. A load returns that byte.
- R4: A store to the D, X, Y or Z page register is ignored when that register is configured absent, and the register then reads zero. The indirect-jump page register is always writable.
- R5: A store to 0x5D replaces bits 7:0 of `sp_o` and leaves bits 15:8 unchanged. A load from 0x5D returns bits 7:0.
- R6: A store to 0x5E replaces bits 15:8 of `sp_o` only when a two-byte stack pointer is configured. Otherwise the store is ignored, and loads from 0x5E return zero.
- R7: A store to 0x5F sets `sreg_o`, and a load from 0x5F returns it.
- R8: `rd_rvalid` is high for exactly one cycle after each cycle in which `rd_valid` and `rd_ready` are both high. `rd_rdata` in that cycle holds the byte that was addressed, taken from the state before any store in the same cycle.
- R9: When the read and write channels both target memory in the same cycle, the write owns the memory port and the read waits (`rd_ready` low). A memory request is accepted only in a cycle with `mem_ready` high. Non-memory requests are always ready.
- R10: After reset, every local register is zero and `rd_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_valid | input | 1 | Load request |
| rd_addr | input | AW | Load data address |
| rd_ready | output | 1 | Load accepted this cycle |
| rd_rvalid | output | 1 | Load data valid |
| rd_rdata | output | 8 | Load data |
| wr_valid | input | 1 | Store request |
| wr_addr | input | AW | Store data address |
| wr_data | input | 8 | Store byte |
| wr_ready | output | 1 | Store accepted this cycle |
| rf_rd_idx | output | RIW | Register file read index |
| rf_rd_data | input | 8 | Register file read byte |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_wr_idx | output | RIW | Register file write index |
| rf_wr_data | output | 8 | Register file write byte |
| mem_valid | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ready | input | 1 | Memory accepts request |
| mem_rdata | input | 8 | Memory read byte, valid with mem_ready |
| sp_o | output | 16 | Stack pointer |
| sreg_o | output | 8 | Status register |
| page_d_o | output | 24 | D page, byte in bits 23:16 |
| page_x_o | output | 24 | X page, byte in bits 23:16 |
| page_y_o | output | 24 | Y page, byte in bits 23:16 |
| page_z_o | output | 24 | Z page, byte in bits 23:16 |
| ijmp_page_o | output | 24 | Indirect-jump page, byte in bits 23:16 |

## Verification
On every cycle the assertions check that the memory port never carries a register-file or locally held address, and that a register-file store never coincides with a memory write. They also check that a stalled store means memory is busy with that store, that read data appears only after an accepted read, and that a low stack-pointer store keeps the high byte. The exact byte stored in each local register, the per-feature ignoring of stores, write-over-read arbitration, and the address boundaries at 0x1F/0x20, 0x57/0x58 and 0x5F/0x60 are shown only by the bench. It runs two configurations, one with every feature present and one with the D and Y pages and the high stack byte removed, against a cycle-accurate model.

// File: rtl/dspace_router.sv
module dspace_router #(
  parameter int AW = 16,
  parameter int REG_COUNT = 32,
  parameter int IO_COUNT = 64,
  parameter bit HAS_PAGE_D = 1'b1,
  parameter bit HAS_PAGE_X = 1'b1,
  parameter bit HAS_PAGE_Y = 1'b1,
  parameter bit HAS_PAGE_Z = 1'b1,
  parameter bit HAS_SP_HI = 1'b1,
  localparam int RIW = $clog2(REG_COUNT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_valid,
  input  logic [AW-1:0]  rd_addr,
  output logic           rd_ready,
  output logic           rd_rvalid,
  output logic [7:0]     rd_rdata,
  input  logic           wr_valid,
  input  logic [AW-1:0]  wr_addr,
  input  logic [7:0]     wr_data,
  output logic           wr_ready,
  output logic [RIW-1:0] rf_rd_idx,
  input  logic [7:0]     rf_rd_data,
  output logic           rf_wr_en,
  output logic [RIW-1:0] rf_wr_idx,
  output logic [7:0]     rf_wr_data,
  output logic           mem_valid,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [7:0]     mem_wdata,
  input  logic           mem_ready,
  input  logic [7:0]     mem_rdata,
  output logic [15:0]    sp_o,
  output logic [7:0]     sreg_o,
  output logic [23:0]    page_d_o,
  output logic [23:0]    page_x_o,
  output logic [23:0]    page_y_o,
  output logic [23:0]    page_z_o,
  output logic [23:0]    ijmp_page_o
);
  localparam int LOC_PORT0 = 'h38;
  localparam logic [AW-1:0] RF_END = AW'(REG_COUNT);
  localparam logic [AW-1:0] LOC_A  = AW'(REG_COUNT + LOC_PORT0);
  localparam logic [AW-1:0] MEM_A  = AW'(REG_COUNT + IO_COUNT);
  localparam logic [AW-1:0] SPL_A  = LOC_A + AW'(5);
  localparam logic [AW-1:0] SPH_A  = LOC_A + AW'(6);
  localparam logic [4:0] PG_EN = {1'b1, HAS_PAGE_Z, HAS_PAGE_Y, HAS_PAGE_X, HAS_PAGE_D};

  typedef enum logic [1:0] {TGT_RF, TGT_LOC, TGT_MEM} tgt_t;

  function automatic tgt_t decode(input logic [AW-1:0] a);
    if (a < RF_END) return TGT_RF;
    if (a >= LOC_A && a < MEM_A) return TGT_LOC;
    return TGT_MEM;
  endfunction

  tgt_t rd_tgt, wr_tgt;
  logic wr_mem, rd_mem, wr_loc;
  logic [AW-1:0] rd_off, wr_off;
  logic [2:0] rsel, wsel;
  logic [7:0] page [5];
  logic [7:0] sp_lo, sp_hi, sreg_q, loc_rd;

  assign rd_tgt = decode(rd_addr);
  assign wr_tgt = decode(wr_addr);
  assign rd_off = rd_addr - LOC_A;
  assign wr_off = wr_addr - LOC_A;
  assign rsel = rd_off[2:0];
  assign wsel = wr_off[2:0];
  assign wr_mem = wr_valid && wr_tgt == TGT_MEM;
  assign rd_mem = rd_valid && rd_tgt == TGT_MEM;
  assign wr_loc = wr_valid && wr_tgt == TGT_LOC;

  assign mem_valid = wr_mem || rd_mem;
  assign mem_we    = wr_mem;
  assign mem_addr  = wr_mem ? wr_addr : rd_addr;
  assign mem_wdata = wr_data;
  assign wr_ready  = !wr_mem || mem_ready;
  assign rd_ready  = !rd_mem || (mem_ready && !wr_mem);

  assign rf_wr_en   = wr_valid && wr_tgt == TGT_RF;
  assign rf_wr_idx  = wr_addr[RIW-1:0];
  assign rf_wr_data = wr_data;
  assign rf_rd_idx  = rd_addr[RIW-1:0];

  for (genvar g = 0; g < 5; g++) begin : g_page
    if (PG_EN[g]) begin : g_on
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) page[g] <= '0;
        else if (wr_loc && wsel == 3'(g)) page[g] <= wr_data;
    end else begin : g_off
      assign page[g] = '0;
    end
  end

  if (HAS_SP_HI) begin : g_sphi
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sp_hi <= '0;
      else if (wr_loc && wsel == 3'd6) sp_hi <= wr_data;
  end else begin : g_nosphi
    assign sp_hi = '0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sp_lo  <= '0;
      sreg_q <= '0;
    end else if (wr_loc) begin
      if (wsel == 3'd5) sp_lo <= wr_data;
      if (wsel == 3'd7) sreg_q <= wr_data;
    end

  always_comb
    case (rsel)
      3'd5:    loc_rd = sp_lo;
      3'd6:    loc_rd = sp_hi;
      3'd7:    loc_rd = sreg_q;
      default: loc_rd = page[rsel];
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_rvalid <= 1'b0;
      rd_rdata  <= '0;
    end else begin
      rd_rvalid <= rd_valid && rd_ready;
      if (rd_valid && rd_ready)
        case (rd_tgt)
          TGT_RF:  rd_rdata <= rf_rd_data;
          TGT_LOC: rd_rdata <= loc_rd;
          default: rd_rdata <= mem_rdata;
        endcase
    end

  assign sp_o        = {sp_hi, sp_lo};
  assign sreg_o      = sreg_q;
  assign page_d_o    = {page[0], 16'h0};
  assign page_x_o    = {page[1], 16'h0};
  assign page_y_o    = {page[2], 16'h0};
  assign page_z_o    = {page[3], 16'h0};
  assign ijmp_page_o = {page[4], 16'h0};

  assert_rf_no_memwr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> !(mem_valid && mem_we));

  assert_mem_never_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr >= MEM_A || (mem_addr >= RF_END && mem_addr < LOC_A)));

  assert_spl_keeps_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == SPL_A) |=> sp_o[15:8] == $past(sp_o[15:8]));

  assert_sph_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_SP_HI && rd_rvalid && $past(rd_addr) == SPH_A) |-> rd_rdata == 8'h00);

  assert_rvalid_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rvalid |-> $past(rd_valid && rd_ready));

  assert_wr_stall_is_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> (mem_valid && mem_we && !mem_ready));
endmodule

// File: tb/dspace_router_bench.sv
module dspace_router_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rd_valid = 0, wr_valid = 0, mem_ready = 1;
  logic [15:0] rd_addr = 0, wr_addr = 0;
  logic [7:0] wr_data = 0;

  logic rd_ready [2], rd_rvalid [2], wr_ready [2], rf_wr_en [2];
  logic mem_valid [2], mem_we [2];
  logic [7:0] rd_rdata [2], rf_rd_data [2], rf_wr_data [2], mem_wdata [2], mem_rdata [2], sreg_o [2];
  logic [4:0] rf_rd_idx [2], rf_wr_idx [2];
  logic [15:0] mem_addr [2], sp_o [2];
  logic [23:0] pg [2][5];

  int checks = 0, bad = 0;
  int m_page [2][5];
  int m_sp [2], m_sreg [2], m_rv [2], m_rd [2];
  bit fe [2][5] = '{'{1,1,1,1,1}, '{0,1,0,1,1}};
  bit sph [2] = '{1, 0};

  function automatic logic [7:0] rf_f(input int i);
    return 8'(i * 7 + 3);
  endfunction
  function automatic logic [7:0] mem_f(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h96;
  endfunction

  for (genvar k = 0; k < 2; k++) begin : g_drv
    assign rf_rd_data[k] = rf_f(int'(rf_rd_idx[k]));
    assign mem_rdata[k]  = mem_f(int'(mem_addr[k]));
  end

  dspace_router u_dspace_router (
    .clk, .rst_n, .rd_valid, .rd_addr, .rd_ready(rd_ready[0]), .rd_rvalid(rd_rvalid[0]),
    .rd_rdata(rd_rdata[0]), .wr_valid, .wr_addr, .wr_data, .wr_ready(wr_ready[0]),
    .rf_rd_idx(rf_rd_idx[0]), .rf_rd_data(rf_rd_data[0]), .rf_wr_en(rf_wr_en[0]),
    .rf_wr_idx(rf_wr_idx[0]), .rf_wr_data(rf_wr_data[0]), .mem_valid(mem_valid[0]),
    .mem_we(mem_we[0]), .mem_addr(mem_addr[0]), .mem_wdata(mem_wdata[0]), .mem_ready,
    .mem_rdata(mem_rdata[0]), .sp_o(sp_o[0]), .sreg_o(sreg_o[0]), .page_d_o(pg[0][0]),
    .page_x_o(pg[0][1]), .page_y_o(pg[0][2]), .page_z_o(pg[0][3]), .ijmp_page_o(pg[0][4]));

  dspace_router #(.HAS_PAGE_D(1'b0), .HAS_PAGE_Y(1'b0), .HAS_SP_HI(1'b0)) u_dspace_router_lite (
    .clk, .rst_n, .rd_valid, .rd_addr, .rd_ready(rd_ready[1]), .rd_rvalid(rd_rvalid[1]),
    .rd_rdata(rd_rdata[1]), .wr_valid, .wr_addr, .wr_data, .wr_ready(wr_ready[1]),
    .rf_rd_idx(rf_rd_idx[1]), .rf_rd_data(rf_rd_data[1]), .rf_wr_en(rf_wr_en[1]),
    .rf_wr_idx(rf_wr_idx[1]), .rf_wr_data(rf_wr_data[1]), .mem_valid(mem_valid[1]),
    .mem_we(mem_we[1]), .mem_addr(mem_addr[1]), .mem_wdata(mem_wdata[1]), .mem_ready,
    .mem_rdata(mem_rdata[1]), .sp_o(sp_o[1]), .sreg_o(sreg_o[1]), .page_d_o(pg[1][0]),
    .page_x_o(pg[1][1]), .page_y_o(pg[1][2]), .page_z_o(pg[1][3]), .ijmp_page_o(pg[1][4]));

  function automatic int region(input int a);
    if (a < 32) return 0;
    if (a < 88) return 2;
    if (a < 96) return 1;
    return 2;
  endfunction

  function automatic int loc_rd(input int k, input int p);
    if (p < 5) return m_page[k][p];
    if (p == 5) return m_sp[k] & 255;
    if (p == 6) return m_sp[k] >> 8;
    return m_sreg[k];
  endfunction

  task automatic chk(input string tag, input int k, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s inst%0d %s actual=%0h expected=%0h", tag, k, what, act, exp);
    end
  endtask

  task automatic compare();
    for (int k = 0; k < 2; k++) begin
      bit wm = wr_valid && region(int'(wr_addr)) == 2;
      bit rm = rd_valid && region(int'(rd_addr)) == 2;
      chk("R9", k, "mem_valid", int'(mem_valid[k]), int'(wm || rm));
      if (wm || rm) begin
        chk("R9", k, "mem_we", int'(mem_we[k]), int'(wm));
        chk("R2", k, "mem_addr", int'(mem_addr[k]), wm ? int'(wr_addr) : int'(rd_addr));
      end
      if (wm) chk("R2", k, "mem_wdata", int'(mem_wdata[k]), int'(wr_data));
      if (wr_valid) chk("R9", k, "wr_ready", int'(wr_ready[k]), wm ? int'(mem_ready) : 1);
      if (rd_valid) chk("R9", k, "rd_ready", int'(rd_ready[k]), rm ? int'(mem_ready && !wm) : 1);
      chk("R1", k, "rf_wr_en", int'(rf_wr_en[k]), int'(wr_valid && region(int'(wr_addr)) == 0));
      if (wr_valid && region(int'(wr_addr)) == 0) begin
        chk("R1", k, "rf_wr_idx", int'(rf_wr_idx[k]), int'(wr_addr[4:0]));
        chk("R1", k, "rf_wr_data", int'(rf_wr_data[k]), int'(wr_data));
      end
      chk("R8", k, "rd_rvalid", int'(rd_rvalid[k]), m_rv[k]);
      if (m_rv[k] != 0) chk("R8", k, "rd_rdata", int'(rd_rdata[k]), m_rd[k]);
      for (int j = 0; j < 5; j++)
        chk(fe[k][j] ? "R3" : "R4", k, "page", int'(pg[k][j]), m_page[k][j] << 16);
      chk("R5", k, "sp_lo", int'(sp_o[k][7:0]), m_sp[k] & 255);
      chk("R6", k, "sp_hi", int'(sp_o[k][15:8]), m_sp[k] >> 8);
      chk("R7", k, "sreg", int'(sreg_o[k]), m_sreg[k]);
    end
  endtask

  task automatic update();
    for (int k = 0; k < 2; k++) begin
      int ra = int'(rd_addr), wa = int'(wr_addr), wd = int'(wr_data);
      bit wm = wr_valid && region(wa) == 2;
      bit rm = rd_valid && region(ra) == 2;
      bit acc = rd_valid && (rm ? (mem_ready && !wm) : 1'b1);
      if (!rst_n) begin
        m_sp[k] = 0; m_sreg[k] = 0; m_rv[k] = 0; m_rd[k] = 0;
        for (int j = 0; j < 5; j++) m_page[k][j] = 0;
      end else begin
        m_rv[k] = int'(acc);
        if (acc) begin
          case (region(ra))
            0: m_rd[k] = int'(rf_f(ra & 31));
            1: m_rd[k] = loc_rd(k, ra - 88);
            default: m_rd[k] = int'(mem_f(ra));
          endcase
        end
        if (wr_valid && region(wa) == 1) begin
          int p = wa - 88;
          if (p < 5) begin
            if (fe[k][p]) m_page[k][p] = wd;
          end else if (p == 5) m_sp[k] = (m_sp[k] & 'hff00) | wd;
          else if (p == 6) begin
            if (sph[k]) m_sp[k] = (m_sp[k] & 'hff) | (wd << 8);
          end else m_sreg[k] = wd;
        end
      end
    end
  endtask

  task automatic cyc(input bit rv, input int ra, input bit wv, input int wa, input int wd, input bit mr);
    rd_valid = rv; rd_addr = 16'(ra); wr_valid = wv; wr_addr = 16'(wa);
    wr_data = 8'(wd); mem_ready = mr;
    #1;
    compare();
    update();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input int a); cyc(1, a, 0, 0, 0, 1); endtask
  task automatic wr(input int a, input int d); cyc(0, 0, 1, a, d, 1); endtask

  initial begin
    #(CLK_PERIOD * 50000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 1);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 1);
    for (int k = 0; k < 2; k++) begin
      chk("R10", k, "sp after reset", int'(sp_o[k]), 0);
      chk("R10", k, "sreg after reset", int'(sreg_o[k]), 0);
      chk("R10", k, "rvalid after reset", int'(rd_rvalid[k]), 0);
      chk("R10", k, "ijmp after reset", int'(pg[k][4]), 0);
    end
    // R3/R4 page registers
    for (int p = 0; p < 5; p++) wr('h58 + p, 'h11 * (p + 1));
    for (int p = 0; p < 5; p++) rd('h58 + p);
    // R5/R6 stack pointer
    wr('h5D, 'hA7); wr('h5E, 'h3C); wr('h5D, 'h12); rd('h5E); rd('h5D);
    // R7 status
    wr('h5F, 'h81); rd('h5F);
    // R1 register file edges
    wr('h00, 'h5A); wr('h1F, 'hC3); rd('h1F); rd('h00);
    // R2 boundaries
    wr('h20, 'h01); wr('h57, 'h02); wr('h60, 'h03);
    rd('h20); rd('h57); rd('h58); rd('h5F); rd('h60); rd('hFFFF);
    // R9 stalls and arbitration
    cyc(0, 0, 1, 'h100, 'h44, 0); cyc(0, 0, 1, 'h100, 'h44, 0); cyc(0, 0, 1, 'h100, 'h44, 1);
    cyc(1, 'h200, 1, 'h300, 'h55, 1); cyc(1, 'h200, 0, 0, 0, 0); cyc(1, 'h200, 0, 0, 0, 1);
    cyc(1, 'h5C, 1, 'h300, 'h66, 0); cyc(1, 'h1F, 1, 'h5C, 'h77, 1); rd('h5C);
    for (int i = 0; i < 3000; i++) begin
      int ra = ($urandom_range(0, 2) == 0) ? 'h58 + $urandom_range(0, 7) : $urandom_range(0, 130);
      int wa = ($urandom_range(0, 2) == 0) ? 'h58 + $urandom_range(0, 7) : $urandom_range(0, 130);
      cyc(1'($urandom_range(0, 1)), ra, 1'($urandom_range(0, 1)), wa,
          $urandom_range(0, 255), 1'($urandom_range(0, 3) != 0));
    end
    cyc(0, 0, 0, 0, 0, 1);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule